// File: doc/BRIEF.md
# Microcoded 16-bit ALU Datapath

This block is the arithmetic and register section of a small 16-bit processor. Each clock cycle a set of microword fields steers it. An operand multiplexer picks the first ALU operand from one of three bus-side registers or from an external data word. The three registers are the address register, the receive register and the transmit register. The second operand is read from a 12-entry register file. The ALU offers 32 functions: 16 bitwise logic functions and 16 arithmetic functions.

On a cycle with the execute strobe high, a destination field decides where the result lands: the register file, the address register, the transmit register, or nowhere. The carry, zero, sign and overflow flags are captured on the same edge. The receive register is filled from the bus side through its own load strobe. A second read port on the register file lets the surrounding logic observe any entry.

Top module: `alu_datapath`

## Requirements
- R1: While reset is asserted and for two cycles after its release, the address, receive and transmit registers, all register file entries and all four flags read as zero.
- R2: Operand A comes from the source field `src_i`. The codes are 0 = address register, 1 = receive register, 2 = transmit register, 3 = `din_i`. Operand B is the register file entry indexed by `bidx_i`.
- R3: With `mode_i` = 0, the function is logic. Result bit i equals bit `fsel_i[{A[i],B[i]}]`, so 0 gives all zeros, 1 NOR, 3 NOT A, 6 XOR, 8 AND, 9 XNOR, 10 pass B, 12 pass A, 14 OR and 15 all ones. Carry-in is ignored, and carry-out and overflow are zero.
- R4: With `mode_i` = 1, the result is X + Y + `cin_i` for the operand pair (X, Y) selected by `fsel_i`. The codes are 0:(A,0) 1:(A,B) 2:(A,~B) 3:(A,A) 4:(A,all ones) 5:(B,0) 6:(B,~A) 7:(B,all ones) 8:(A&B,0) 9:(A|B,0) 10:(A,A&B) 11:(A,A|B) 12:(A,A&~B) 13:(A^B,0) 14:(~A,0) 15:(B,B).
- R5: `result_o` shows the ALU result combinationally. The flags update only on a clock edge where `exec_i` is 1 and hold otherwise.
- R6: When `exec_i` is 1, `dest_i` picks the target: 0 = none, 1 = register file entry `widx_i`, 2 = address register, 3 = transmit register. Targets that are not picked keep their value.
- R7: When `exec_i` is 0, no register file entry, address register or transmit register changes.
- R8: A write to an index of 12 or above changes no entry. A read from an index of 12 or above, on either read port, returns zero.
- R9: When `rcv_load_i` is 1, the receive register takes `rcv_data_i` on the next edge, independent of `exec_i`.
- R10: Carry-out is bit 16 of the 17-bit sum. Overflow is set when X and Y have the same sign and the result sign differs from them. Zero is set when the result is all zeros. Sign is result bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe: commit result and flags |
| mode_i | input | 1 | 0 = logic, 1 = arithmetic |
| fsel_i | input | 4 | Function select |
| cin_i | input | 1 | Carry-in (arithmetic only) |
| src_i | input | 2 | Operand A source |
| bidx_i | input | 4 | Register file index for operand B |
| dest_i | input | 2 | Result destination |
| widx_i | input | 4 | Register file write index |
| din_i | input | 16 | External data word |
| rcv_load_i | input | 1 | Receive register load strobe |
| rcv_data_i | input | 16 | Receive register load data |
| rd_idx_i | input | 4 | Observation read index |
| rd_data_o | output | 16 | Observation read data |
| addr_o | output | 16 | Address register |
| rcv_o | output | 16 | Receive register |
| xmit_o | output | 16 | Transmit register |
| result_o | output | 16 | ALU result (combinational) |
| cout_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench builds the block with its defaults: 16-bit data, 12 entries and 4-bit indexes. With these values the indexes 12 to 15 exist on every index port, so the ignored writes and the zero reads are reachable with ordinary stimulus. The 16-bit width also puts the signed overflow boundary at 0x7FFF and the carry boundary at 0xFFFF, and directed cases hit both. Random operations cover all 32 functions, every source and destination code, and idle cycles.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;
  typedef enum logic [1:0] {
    SRC_ADDR = 2'd0,
    SRC_RCV  = 2'd1,
    SRC_XMIT = 2'd2,
    SRC_DIN  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RF   = 2'd1,
    DST_ADDR = 2'd2,
    DST_XMIT = 2'd3
  } dst_e;

  typedef struct packed {
    logic cy;
    logic zr;
    logic sg;
    logic ov;
  } flags_t;
endpackage

// File: rtl/dp_opnd_mux.sv
module dp_opnd_mux #(
  parameter int DW = 16
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] rcv,
  input  logic [DW-1:0] xmit,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] opnd
);
  import alu_dp_pkg::*;

  always_comb begin
    unique case (src_e'(sel))
      SRC_ADDR: opnd = addr;
      SRC_RCV:  opnd = rcv;
      SRC_XMIT: opnd = xmit;
      default:  opnd = din;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          mode,
  input  logic [3:0]    fsel,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          ovf
);
  logic [DW-1:0] x, y, lres;
  logic [DW:0]   sum;

  always_comb begin
    case (fsel)
      4'd0:    begin x = a;      y = '0;      end
      4'd1:    begin x = a;      y = b;       end
      4'd2:    begin x = a;      y = ~b;      end
      4'd3:    begin x = a;      y = a;       end
      4'd4:    begin x = a;      y = '1;      end
      4'd5:    begin x = b;      y = '0;      end
      4'd6:    begin x = b;      y = ~a;      end
      4'd7:    begin x = b;      y = '1;      end
      4'd8:    begin x = a & b;  y = '0;      end
      4'd9:    begin x = a | b;  y = '0;      end
      4'd10:   begin x = a;      y = a & b;   end
      4'd11:   begin x = a;      y = a | b;   end
      4'd12:   begin x = a;      y = a & ~b;  end
      4'd13:   begin x = a ^ b;  y = '0;      end
      4'd14:   begin x = ~a;     y = '0;      end
      default: begin x = b;      y = b;       end
    endcase
    sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  end

  // Logic mode: each result bit is a lookup of fsel by the operand bit pair.
  always_comb begin
    for (int i = 0; i < DW; i++) begin
      lres[i] = fsel[{a[i], b[i]}];
    end
  end

  always_comb begin
    if (mode) begin
      res  = sum[DW-1:0];
      cout = sum[DW];
      ovf  = (x[DW-1] == y[DW-1]) && (sum[DW-1] != x[DW-1]);
    end else begin
      res  = lres;
      cout = 1'b0;
      ovf  = 1'b0;
    end
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 12,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [NREG];

  for (genvar e = 0; e < NREG; e++) begin : g_ent
    logic ent_we;
    assign ent_we = we && (widx == IW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[e] <= '0;
      else if (ent_we) mem[e] <= wdata;
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int e = 0; e < NREG; e++) begin
      if (ridx_a == IW'(e)) rdata_a = mem[e];
      if (ridx_b == IW'(e)) rdata_b = mem[e];
    end
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath #(
  parameter int DW   = 16,
  parameter int NREG = 12,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic          mode_i,
  input  logic [3:0]    fsel_i,
  input  logic          cin_i,
  input  logic [1:0]    src_i,
  input  logic [IW-1:0] bidx_i,
  input  logic [1:0]    dest_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] din_i,
  input  logic          rcv_load_i,
  input  logic [DW-1:0] rcv_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] rcv_o,
  output logic [DW-1:0] xmit_o,
  output logic [DW-1:0] result_o,
  output logic          cout_o,
  output logic          zero_o,
  output logic          sign_o,
  output logic          ovf_o
);
  import alu_dp_pkg::*;

  // Reset: asserted asynchronously, released after two clean edges.
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [DW-1:0] addr_q, rcv_q, xmit_q;
  logic [DW-1:0] addr_d, rcv_d, xmit_d;
  flags_t        flg_q, flg_d;
  logic [DW-1:0] opnd_a, opnd_b, alu_res;
  logic          alu_cy, alu_ov, rf_we;
  dst_e          dst;

  assign dst = dst_e'(dest_i);

  dp_opnd_mux #(.DW(DW)) u_mux (
    .sel  (src_i),
    .addr (addr_q),
    .rcv  (rcv_q),
    .xmit (xmit_q),
    .din  (din_i),
    .opnd (opnd_a)
  );

  dp_alu #(.DW(DW)) u_alu (
    .a    (opnd_a),
    .b    (opnd_b),
    .mode (mode_i),
    .fsel (fsel_i),
    .cin  (cin_i),
    .res  (alu_res),
    .cout (alu_cy),
    .ovf  (alu_ov)
  );

  assign rf_we = exec_i && (dst == DST_RF);

  dp_regfile #(.DW(DW), .NREG(NREG), .IW(IW)) u_rf (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .we      (rf_we),
    .widx    (widx_i),
    .wdata   (alu_res),
    .ridx_a  (bidx_i),
    .rdata_a (opnd_b),
    .ridx_b  (rd_idx_i),
    .rdata_b (rd_data_o)
  );

  // Next-state logic
  always_comb begin
    addr_d = addr_q;
    xmit_d = xmit_q;
    rcv_d  = rcv_q;
    flg_d  = flg_q;
    if (rcv_load_i) rcv_d = rcv_data_i;
    if (exec_i) begin
      if (dst == DST_ADDR) addr_d = alu_res;
      if (dst == DST_XMIT) xmit_d = alu_res;
      flg_d.cy = alu_cy;
      flg_d.zr = (alu_res == '0);
      flg_d.sg = alu_res[DW-1];
      flg_d.ov = alu_ov;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      addr_q <= '0;
      xmit_q <= '0;
      rcv_q  <= '0;
      flg_q  <= '0;
    end else begin
      addr_q <= addr_d;
      xmit_q <= xmit_d;
      rcv_q  <= rcv_d;
      flg_q  <= flg_d;
    end
  end

  assign addr_o   = addr_q;
  assign rcv_o    = rcv_q;
  assign xmit_o   = xmit_q;
  assign result_o = alu_res;
  assign cout_o   = flg_q.cy;
  assign zero_o   = flg_q.zr;
  assign sign_o   = flg_q.sg;
  assign ovf_o    = flg_q.ov;
endmodule

// File: rtl/alu_dp_chk.sv
module alu_dp_chk #(
  parameter int DW   = 16,
  parameter int NREG = 12,
  parameter int IW   = 4
) (
  input logic          clk,
  input logic          core_rst_n,
  input logic          exec_i,
  input logic          mode_i,
  input logic [1:0]    dest_i,
  input logic          rcv_load_i,
  input logic [DW-1:0] rcv_data_i,
  input logic [IW-1:0] rd_idx_i,
  input logic [DW-1:0] rd_data_o,
  input logic [DW-1:0] addr_o,
  input logic [DW-1:0] rcv_o,
  input logic [DW-1:0] xmit_o,
  input logic [DW-1:0] result_o,
  input logic          cout_o,
  input logic          zero_o,
  input logic          sign_o,
  input logic          ovf_o
);
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    !exec_i |=> $stable({cout_o, zero_o, sign_o, ovf_o}));

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    exec_i |=> (zero_o == ($past(result_o) == '0)));

  p_sign_flag_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    exec_i |=> (sign_o == $past(result_o[DW-1])));

  p_logic_nocarry_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (exec_i && !mode_i) |=> (!cout_o && !ovf_o));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(exec_i && dest_i == 2'd2) |=> $stable(addr_o));

  p_xmit_hold_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(exec_i && dest_i == 2'd3) |=> $stable(xmit_o));

  p_addr_write_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (exec_i && dest_i == 2'd2) |=> (addr_o == $past(result_o)));

  p_rcv_load_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    rcv_load_i |=> (rcv_o == $past(rcv_data_i)));

  p_oob_read_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (int'(rd_idx_i) >= NREG) |-> (rd_data_o == '0));
endmodule

bind alu_datapath alu_dp_chk #(.DW(DW), .NREG(NREG), .IW(IW)) u_chk (.*);

// File: tb/sim_alu_datapath.sv
`timescale 1ns/1ps
module sim_alu_datapath;
  localparam int DW = 16;
  localparam int NREG = 12;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic exec_i, mode_i, cin_i, rcv_load_i;
  logic [3:0] fsel_i;
  logic [1:0] src_i, dest_i;
  logic [IW-1:0] bidx_i, widx_i, rd_idx_i;
  logic [DW-1:0] din_i, rcv_data_i;
  logic [DW-1:0] rd_data_o, addr_o, rcv_o, xmit_o, result_o;
  logic cout_o, zero_o, sign_o, ovf_o;

  always #4 clk = ~clk;

  alu_datapath #(.DW(DW), .NREG(NREG), .IW(IW)) u0 (.*);

  int n_run = 0;
  int n_fail = 0;

  logic [DW-1:0] m_rf [NREG];
  logic [DW-1:0] m_addr, m_rcv, m_xmit;
  logic m_cy, m_zr, m_sg, m_ov;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] m_read(input logic [IW-1:0] idx);
    return (int'(idx) < NREG) ? m_rf[idx] : '0;
  endfunction

  // Reference: returns {carry, overflow, result}
  function automatic logic [DW+1:0] ref_alu(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic md, input logic [3:0] f, input logic c);
    logic [DW-1:0] x, y, r;
    logic [31:0] s;
    if (!md) begin
      for (int i = 0; i < DW; i++) r[i] = f[2*a[i] + b[i]];
      return {2'b00, r};
    end
    case (f)
      0: begin x = a; y = 0; end
      1: begin x = a; y = b; end
      2: begin x = a; y = ~b; end
      3: begin x = a; y = a; end
      4: begin x = a; y = 16'hFFFF; end
      5: begin x = b; y = 0; end
      6: begin x = b; y = ~a; end
      7: begin x = b; y = 16'hFFFF; end
      8: begin x = a & b; y = 0; end
      9: begin x = a | b; y = 0; end
      10: begin x = a; y = a & b; end
      11: begin x = a; y = a | b; end
      12: begin x = a; y = a & ~b; end
      13: begin x = a ^ b; y = 0; end
      14: begin x = ~a; y = 0; end
      default: begin x = b; y = b; end
    endcase
    s = 32'(x) + 32'(y) + 32'(c);
    r = s[DW-1:0];
    return {s[DW], (x[DW-1] == y[DW-1]) && (r[DW-1] != x[DW-1]), r};
  endfunction

  task automatic op(input logic ex, input logic md, input logic [3:0] f, input logic c,
                    input logic [1:0] src, input logic [IW-1:0] bi, input logic [1:0] dst,
                    input logic [IW-1:0] wi, input logic [DW-1:0] d,
                    input logic ld, input logic [DW-1:0] ldat, input logic [IW-1:0] ri);
    logic [DW-1:0] a, b;
    logic [DW+1:0] e;
    @(negedge clk);
    exec_i = ex; mode_i = md; fsel_i = f; cin_i = c; src_i = src; bidx_i = bi;
    dest_i = dst; widx_i = wi; din_i = d; rcv_load_i = ld; rcv_data_i = ldat;
    case (src)
      0: a = m_addr;
      1: a = m_rcv;
      2: a = m_xmit;
      default: a = d;
    endcase
    b = m_read(bi);
    e = ref_alu(a, b, md, f, c);
    #1;
    chk(md ? "R4 arith result" : "R3 logic result", 32'(result_o), 32'(e[DW-1:0]));
    @(posedge clk);
    if (ld) m_rcv = ldat;
    if (ex) begin
      if (dst == 1 && int'(wi) < NREG) m_rf[wi] = e[DW-1:0];
      if (dst == 2) m_addr = e[DW-1:0];
      if (dst == 3) m_xmit = e[DW-1:0];
      m_cy = e[DW+1]; m_ov = e[DW]; m_zr = (e[DW-1:0] == 0); m_sg = e[DW-1];
    end
    @(negedge clk);
    exec_i = 1'b0; rcv_load_i = 1'b0; rd_idx_i = ri;
    #1;
    chk("R5/R10 flags", {28'd0, cout_o, zero_o, sign_o, ovf_o}, {28'd0, m_cy, m_zr, m_sg, m_ov});
    chk("R6/R7 address reg", 32'(addr_o), 32'(m_addr));
    chk("R6/R7 transmit reg", 32'(xmit_o), 32'(m_xmit));
    chk("R9 receive reg", 32'(rcv_o), 32'(m_rcv));
    chk("R6/R8 regfile read", 32'(rd_data_o), 32'(m_read(ri)));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; exec_i = 0; mode_i = 0; fsel_i = 0; cin_i = 0; src_i = 0; bidx_i = 0;
    dest_i = 0; widx_i = 0; din_i = 0; rcv_load_i = 0; rcv_data_i = 0; rd_idx_i = 0;
    m_addr = 0; m_rcv = 0; m_xmit = 0; m_cy = 0; m_zr = 0; m_sg = 0; m_ov = 0;
    for (int i = 0; i < NREG; i++) m_rf[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset regs", {addr_o, xmit_o}, 32'd0);
    chk("R1 reset flags", {28'd0, cout_o, zero_o, sign_o, ovf_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rd_idx_i = IW'(i); #1;
      chk("R1 R8 regfile after reset", 32'(rd_data_o), 32'd0);
    end
    // Directed corners
    op(1, 0, 4'd12, 0, 3, 0, 1, 0, 16'h7FFF, 1, 16'hA5A5, 0);   // pass A into r0 (R3)
    op(1, 1, 4'd1, 0, 3, 0, 2, 0, 16'h0001, 0, 0, 0);           // 7FFF+1 overflow R10
    chk("R10 overflow set", {31'd0, ovf_o}, 32'd1);
    op(1, 1, 4'd0, 1, 3, 0, 3, 0, 16'hFFFF, 0, 0, 0);           // FFFF+cin carry/zero R10
    chk("R10 carry and zero", {30'd0, cout_o, zero_o}, 32'd3);
    op(1, 0, 4'd15, 1, 1, 0, 1, 4'd13, 0, 0, 0, 4'd13);         // write idx 13 ignored R8
    op(0, 1, 4'd3, 0, 2, 0, 1, 4'd2, 16'h1234, 0, 0, 4'd2);     // no exec: no write R7
    chk("R7 r2 untouched", 32'(rd_data_o), 32'd0);
    op(1, 0, 4'd6, 1, 1, 0, 0, 4'd3, 0, 0, 0, 4'd3);            // XOR dest none R3 R6
    op(1, 1, 4'd2, 1, 0, 0, 1, 4'd11, 0, 0, 0, 4'd11);          // subtract into last entry
    // Random operations
    for (int k = 0; k < 600; k++) begin
      op(($urandom % 5) != 0, $urandom % 2, 4'($urandom), $urandom % 2, 2'($urandom),
         4'($urandom), 2'($urandom), 4'($urandom), 16'($urandom),
         ($urandom % 3) == 0, 16'($urandom), 4'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule